// File: doc/BRIEF.md
# Serial EEPROM Status and Write-Guard Unit

This unit keeps the status/control byte of a serial EEPROM controller and judges every write request the command decoder raises. Decoded strobes arrive from that decoder: latch-enable, latch-disable, a write request flagged as either a status write or an array write, the end of the internal write cycle, and the end of a read access. The unit also sees the level of the active-low hardware protect pin and the 17-bit array address of the request.

A request gets a grant or a deny pulse in the same cycle. The decision draws on three inputs. The first is the write latch. The second is the pairing of the pin with the pin-enable bit. The third is the two-bit block-protect field, which covers the top quarter, the top half or the whole array. A volatile select bit steers accesses to a separate identification page. A one-way lock bit makes that page read-only for good.

The pin-enable bit, the block-protect field and the lock are modelled as flops that keep their value through the asynchronous soft reset. The latch, the select bit and the busy flag clear on reset.

Top module: `eeprom_wp_ctrl`

## Requirements
- R1: `status_o` reads {pin-enable, page-select, 0, page-lock, bp[1], bp[0], latch, busy} from bit 7 down to bit 0, so bit 5 is always 0.
- R2: A granted request sets busy (bit 0) on the next cycle. Busy stays 1 until `wr_done_i` is seen while busy, and reads 0 from the following cycle.
- R3: `wren_i` sets the latch (bit 1) and `wrdi_i` clears it. When both arrive together, `wrdi_i` wins. Completion of a write cycle clears the latch. Every request made while the latch is 0 is denied.
- R4: For an array write with page-select 0, the bp field (bits 3:2) refuses these addresses: 0 none; 1 those with addr[16:15]=11; 2 those with addr[16]=1; 3 all.
- R5: When pin-enable is 1 and `wp_n_i` is 0, status writes are denied. Array writes outside the bp range are still granted while the latch is 1.
- R6: When `wp_n_i` is 1 or pin-enable is 0, a status write with latch 1 and not busy is granted. It loads pin-enable from data bit 7, bp from data bits 3:2, page-select from bit 6 and page-lock from bit 4. Data bits 5, 1 and 0 have no effect.
- R7: `id_sel_o` equals page-select. An array write with page-select 1 ignores bp. It is granted unless page-lock is 1, in which case it is denied.
- R8: Page-select clears after `rd_done_i` while idle, or after the completion of an array write cycle. Completion of a status write cycle leaves it unchanged.
- R9: A status write whose data has both bit 6 and bit 4 set leaves page-select and page-lock unchanged.
- R10: Once page-lock is 1, no status write returns it to 0.
- R11: While busy, requests are denied and `wren_i`, `wrdi_i` and `rd_done_i` change nothing. This includes the cycle in which `wr_done_i` arrives.
- R12: Reset clears latch, page-select and busy. Pin-enable, bp and page-lock keep their values.
- R13: `grant_o` and `deny_o` are combinational. Exactly one of them is 1 in a cycle with `wr_req_i`, and both are 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low soft reset |
| wren_i | input | 1 | Set write latch strobe |
| wrdi_i | input | 1 | Clear write latch strobe |
| wr_req_i | input | 1 | Write request strobe |
| sr_tgt_i | input | 1 | Request targets the status byte |
| addr_i | input | 17 | Array byte address of the request |
| sr_data_i | input | 8 | Status write data |
| wr_done_i | input | 1 | Internal write cycle finished |
| rd_done_i | input | 1 | Read access finished |
| wp_n_i | input | 1 | Hardware protect pin, active low |
| status_o | output | 8 | Status byte |
| grant_o | output | 1 | Request accepted |
| deny_o | output | 1 | Request refused |
| id_sel_o | output | 1 | Identification page selected |

## Verification
Two events can coincide in one cycle. The end of a write cycle can arrive together with a fresh latch-enable or a fresh request. Because busy still reads 1 in that cycle, the enable must be dropped and the request denied, which leaves the latch 0 afterwards. The bench drives `wr_done_i` together with `wren_i`, and separately together with `wr_req_i`. It then reads the status byte and the grant/deny pair against its own model of the rules. A second overlap is a status write that tries to raise page-select and page-lock together. That case is checked by reading both bits back after the cycle.

// File: rtl/eeprom_wp_pkg.sv
package eeprom_wp_pkg;

  typedef enum logic [1:0] {
    BP_NONE    = 2'b00,
    BP_QUARTER = 2'b01,
    BP_HALF    = 2'b10,
    BP_FULL    = 2'b11
  } bp_e;

  typedef struct packed {
    logic pin_en;
    logic pg_sel;
    logic zero;
    logic pg_lock;
    bp_e  bp;
    logic wlatch;
    logic busy;
  } stat_t;

  localparam int unsigned SD_PIN_EN = 7;
  localparam int unsigned SD_PG_SEL = 6;
  localparam int unsigned SD_LOCK   = 4;
  localparam int unsigned SD_BP_LO  = 2;

endpackage

// File: rtl/wp_range_chk.sv
module wp_range_chk
  import eeprom_wp_pkg::*;
#(
  parameter int unsigned ADDR_W = 17
) (
  input  bp_e              bp_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic             hit_o
);
  localparam int unsigned TOP = ADDR_W - 1;

  logic [1:0] top2;
  assign top2 = addr_i[TOP -: 2];

  always_comb begin
    unique case (bp_i)
      BP_NONE:    hit_o = 1'b0;
      BP_QUARTER: hit_o = (top2 == 2'b11);
      BP_HALF:    hit_o = top2[1];
      default:    hit_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/wp_permit.sv
module wp_permit (
  input  logic req_i,
  input  logic sr_tgt_i,
  input  logic busy_i,
  input  logic wlatch_i,
  input  logic pin_en_i,
  input  logic wp_n_i,
  input  logic pg_sel_i,
  input  logic pg_lock_i,
  input  logic range_hit_i,
  output logic grant_o,
  output logic deny_o
);
  logic hw_guard;
  logic tgt_ok;

  assign hw_guard = pin_en_i & ~wp_n_i;

  always_comb begin
    if (sr_tgt_i)      tgt_ok = ~hw_guard;
    else if (pg_sel_i) tgt_ok = ~pg_lock_i;
    else               tgt_ok = ~range_hit_i;
  end

  assign grant_o = req_i & ~busy_i & wlatch_i & tgt_ok;
  assign deny_o  = req_i & ~grant_o;
endmodule

// File: rtl/wp_status_regs.sv
module wp_status_regs
  import eeprom_wp_pkg::*;
#(
  parameter logic [3:0] NV_INIT = 4'b0000  // {pin_en, lock, bp}
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wren_i,
  input  logic       wrdi_i,
  input  logic       grant_i,
  input  logic       sr_tgt_i,
  input  logic [7:0] sr_data_i,
  input  logic       wr_done_i,
  input  logic       rd_done_i,
  output stat_t      stat_o
);
  logic       pin_en_q = NV_INIT[3];
  logic       lock_q   = NV_INIT[2];
  logic [1:0] bp_q     = NV_INIT[1:0];
  logic       wlatch_q, sel_q, busy_q, busy_sr_q;

  logic sr_load, both_set, finish;

  assign sr_load  = grant_i & sr_tgt_i;
  assign both_set = sr_data_i[SD_PG_SEL] & sr_data_i[SD_LOCK];
  assign finish   = busy_q & wr_done_i;

  // non-volatile bits: no reset
  always_ff @(posedge clk_i) begin
    if (sr_load) begin
      pin_en_q <= sr_data_i[SD_PIN_EN];
      bp_q     <= sr_data_i[SD_BP_LO +: 2];
      if (!both_set) lock_q <= lock_q | sr_data_i[SD_LOCK];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wlatch_q  <= 1'b0;
      sel_q     <= 1'b0;
      busy_q    <= 1'b0;
      busy_sr_q <= 1'b0;
    end else begin
      if (busy_q) begin
        if (wr_done_i) wlatch_q <= 1'b0;
      end else if (wrdi_i) begin
        wlatch_q <= 1'b0;
      end else if (wren_i) begin
        wlatch_q <= 1'b1;
      end

      if (busy_q) busy_q <= ~wr_done_i;
      else        busy_q <= grant_i;

      if (grant_i) busy_sr_q <= sr_tgt_i;

      if (sr_load && !both_set)
        sel_q <= sr_data_i[SD_PG_SEL];
      else if ((rd_done_i && !busy_q) || (finish && !busy_sr_q))
        sel_q <= 1'b0;
    end
  end

  always_comb begin
    stat_o.pin_en  = pin_en_q;
    stat_o.pg_sel  = sel_q;
    stat_o.zero    = 1'b0;
    stat_o.pg_lock = lock_q;
    stat_o.bp      = bp_e'(bp_q);
    stat_o.wlatch  = wlatch_q;
    stat_o.busy    = busy_q;
  end
endmodule

// File: rtl/eeprom_wp_ctrl.sv
module eeprom_wp_ctrl
  import eeprom_wp_pkg::*;
#(
  parameter int unsigned ADDR_W  = 17,
  parameter logic [3:0]  NV_INIT = 4'b0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wren_i,
  input  logic              wrdi_i,
  input  logic              wr_req_i,
  input  logic              sr_tgt_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        sr_data_i,
  input  logic              wr_done_i,
  input  logic              rd_done_i,
  input  logic              wp_n_i,
  output logic [7:0]        status_o,
  output logic              grant_o,
  output logic              deny_o,
  output logic              id_sel_o
);
  stat_t stat;
  logic  range_hit;
  logic  grant;

  wp_range_chk #(.ADDR_W(ADDR_W)) u_range (
    .bp_i  (stat.bp),
    .addr_i(addr_i),
    .hit_o (range_hit)
  );

  wp_permit u_permit (
    .req_i      (wr_req_i),
    .sr_tgt_i   (sr_tgt_i),
    .busy_i     (stat.busy),
    .wlatch_i   (stat.wlatch),
    .pin_en_i   (stat.pin_en),
    .wp_n_i     (wp_n_i),
    .pg_sel_i   (stat.pg_sel),
    .pg_lock_i  (stat.pg_lock),
    .range_hit_i(range_hit),
    .grant_o    (grant),
    .deny_o     (deny_o)
  );

  wp_status_regs #(.NV_INIT(NV_INIT)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wren_i   (wren_i),
    .wrdi_i   (wrdi_i),
    .grant_i  (grant),
    .sr_tgt_i (sr_tgt_i),
    .sr_data_i(sr_data_i),
    .wr_done_i(wr_done_i),
    .rd_done_i(rd_done_i),
    .stat_o   (stat)
  );

  assign grant_o  = grant;
  assign status_o = stat;
  assign id_sel_o = stat.pg_sel;
endmodule

// File: rtl/eeprom_wp_ctrl_sva.sv
module eeprom_wp_ctrl_sva #(
  parameter int unsigned ADDR_W = 17
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wren_i,
  input logic              wrdi_i,
  input logic              wr_req_i,
  input logic              sr_tgt_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [7:0]        sr_data_i,
  input logic              wr_done_i,
  input logic              rd_done_i,
  input logic              wp_n_i,
  input logic [7:0]        status_o,
  input logic              grant_o,
  input logic              deny_o,
  input logic              id_sel_o
);
  AST_BIT5_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni) status_o[5] == 1'b0); // R1
  AST_BUSY_AFTER_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni) grant_o |=> status_o[0]); // R2
  AST_BUSY_FALL_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni) (status_o[0] && !wr_done_i) |=> status_o[0]); // R2
  AST_NO_GRANT_UNLATCHED: assert property (@(posedge clk_i) disable iff (!rst_ni) !status_o[1] |-> !grant_o); // R3
  AST_LATCH_CLR_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni) (status_o[0] && wr_done_i) |=> !status_o[1]); // R3
  AST_FULL_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni) (wr_req_i && !sr_tgt_i && !id_sel_o && status_o[3:2] == 2'b11) |-> !grant_o); // R4
  AST_HW_GUARD_SR: assert property (@(posedge clk_i) disable iff (!rst_ni) (wr_req_i && sr_tgt_i && status_o[7] && !wp_n_i) |-> !grant_o); // R5
  AST_LOCKED_PAGE: assert property (@(posedge clk_i) disable iff (!rst_ni) (wr_req_i && !sr_tgt_i && id_sel_o && status_o[4]) |-> !grant_o); // R7
  AST_SEL_RD_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni) (rd_done_i && !status_o[0] && !wr_req_i) |=> !id_sel_o); // R8
  AST_BOTH_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni) (grant_o && sr_tgt_i && sr_data_i[6] && sr_data_i[4]) |=> $stable(status_o[6])); // R9
  AST_BOTH_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni) (grant_o && sr_tgt_i && sr_data_i[6] && sr_data_i[4]) |=> $stable(status_o[4])); // R9
  AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni) status_o[4] |=> status_o[4]); // R10
  AST_BUSY_DENY: assert property (@(posedge clk_i) disable iff (!rst_ni) (wr_req_i && status_o[0]) |-> deny_o); // R11
  AST_BUSY_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) (status_o[0] && !wr_done_i) |=> $stable(status_o[1])); // R11
  AST_ONE_RESP: assert property (@(posedge clk_i) disable iff (!rst_ni) wr_req_i |-> (grant_o != deny_o)); // R13
  AST_NO_RESP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni) !wr_req_i |-> !(grant_o || deny_o)); // R13
endmodule

bind eeprom_wp_ctrl eeprom_wp_ctrl_sva #(.ADDR_W(ADDR_W)) u_sva (.*);

// File: tb/eeprom_wp_ctrl_tb.sv
module eeprom_wp_ctrl_tb;
  localparam int AW = 17;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic wren = 0, wrdi = 0, req = 0, srt = 0, done = 0, rdd = 0, wp_n = 1;
  logic [AW-1:0] addr = '0;
  logic [7:0] data = '0;
  logic [7:0] status;
  logic grant, deny, id_sel;

  eeprom_wp_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wren_i(wren), .wrdi_i(wrdi), .wr_req_i(req),
    .sr_tgt_i(srt), .addr_i(addr), .sr_data_i(data), .wr_done_i(done),
    .rd_done_i(rdd), .wp_n_i(wp_n), .status_o(status), .grant_o(grant),
    .deny_o(deny), .id_sel_o(id_sel)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  // model of the requirements
  logic m_pe = 0, m_sel = 0, m_lock = 0, m_wl = 0, m_busy = 0, m_bsr = 0;
  logic [1:0] m_bp = 0;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  function automatic logic in_range(input logic [1:0] bp, input logic [AW-1:0] a);
    case (bp)
      2'd0: return 1'b0;
      2'd1: return a[AW-1:AW-2] == 2'b11;   // R4
      2'd2: return a[AW-1];
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [7:0] exp_stat();
    return {m_pe, m_sel, 1'b0, m_lock, m_bp, m_wl, m_busy};
  endfunction

  task automatic step(input logic en, input logic dis, input logic rq, input logic sr,
                      input logic [AW-1:0] a, input logic [7:0] d, input logic dn,
                      input logic rd, input string r);
    logic eg, ok;
    @(negedge clk);
    wren = en; wrdi = dis; req = rq; srt = sr; addr = a; data = d; done = dn; rdd = rd;
    #1;
    if (sr)         ok = !(m_pe && !wp_n);
    else if (m_sel) ok = !m_lock;
    else            ok = !in_range(m_bp, a);
    eg = rq && !m_busy && m_wl && ok;
    if (rq) begin
      chk(r, grant, eg);
      chk("R13", deny, !eg);
    end else chk("R13", {grant, deny}, 2'b00);
    // model update from pre-edge state
    if (m_busy) begin
      if (dn) begin
        m_wl = 0;
        m_busy = 0;
        if (!m_bsr) m_sel = 0;
      end
    end else begin
      if (dis) m_wl = 0; else if (en) m_wl = 1;
      if (rd && !(eg && sr)) m_sel = 0;
      if (eg) begin
        m_busy = 1;
        m_bsr = sr;
        if (sr) begin
          m_pe = d[7];
          m_bp = d[3:2];
          if (!(d[6] && d[4])) begin
            m_sel = d[6];
            m_lock = m_lock | d[4];
          end
        end
      end
    end
    @(negedge clk);
    wren = 0; wrdi = 0; req = 0; srt = 0; done = 0; rdd = 0;
    chk(r, status, exp_stat());
    chk("R7", id_sel, m_sel);
  endtask

  task automatic idle(input string r);
    step(0, 0, 0, 0, '0, 8'h00, 0, 0, r);
  endtask

  task automatic sr_write(input logic [7:0] d, input string r);
    step(1, 0, 0, 0, '0, 8'h00, 0, 0, "R3");
    step(0, 0, 1, 1, '0, d, 0, 0, r);
    step(0, 0, 0, 0, '0, 8'h00, 1, 0, "R2");
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    m_wl = 0; m_sel = 0; m_busy = 0;
    @(negedge clk);
    rst_n = 1;
    #1;
    chk("R12", status, exp_stat());
  endtask

  logic [AW-1:0] pts [6];

  initial begin
    pts[0] = 17'h00000; pts[1] = 17'h0FFFF; pts[2] = 17'h10000;
    pts[3] = 17'h17FFF; pts[4] = 17'h18000; pts[5] = 17'h1FFFF;
    repeat (2) @(negedge clk);
    rst_n = 1;
    #1;
    // R12 reset state
    chk("R12", status, 8'h00);
    chk("R13", {grant, deny, id_sel}, 3'b000);

    // R3 latch controls
    step(1, 0, 0, 0, '0, 8'h00, 0, 0, "R3");
    step(0, 1, 0, 0, '0, 8'h00, 0, 0, "R3");
    step(1, 0, 0, 0, '0, 8'h00, 0, 0, "R3");
    step(1, 1, 0, 0, '0, 8'h00, 0, 0, "R3");
    step(0, 0, 1, 0, 17'h00010, 8'h00, 0, 0, "R3");

    // R9 and R6: both page bits raised, ignored bits 5,1,0
    sr_write(8'hFF, "R9");
    chk("R1", status[5], 1'b0);
    sr_write(8'h00, "R6");

    // R2 / R11 busy behaviour and coincident completion
    step(1, 0, 0, 0, '0, 8'h00, 0, 0, "R3");
    step(0, 0, 1, 0, 17'h00020, 8'h00, 0, 0, "R2");
    step(0, 1, 0, 0, '0, 8'h00, 0, 0, "R11");
    step(0, 0, 1, 0, 17'h00020, 8'h00, 0, 0, "R11");
    step(0, 0, 0, 0, '0, 8'h00, 0, 1, "R11");
    idle("R2");
    step(1, 0, 0, 0, '0, 8'h00, 1, 0, "R11");
    chk("R11", status[1], 1'b0);
    step(1, 0, 0, 0, '0, 8'h00, 0, 0, "R3");
    step(0, 0, 1, 0, 17'h00040, 8'h00, 0, 0, "R2");
    step(0, 0, 1, 0, 17'h00040, 8'h00, 1, 0, "R11");

    // R7 / R8 identification page
    sr_write(8'h4C, "R6");
    chk("R8", id_sel, 1'b1);
    step(1, 0, 0, 0, '0, 8'h00, 0, 0, "R3");
    step(0, 0, 1, 0, 17'h1FFFF, 8'h00, 0, 0, "R7");
    step(0, 0, 0, 0, '0, 8'h00, 1, 0, "R8");
    sr_write(8'h40, "R6");
    step(0, 0, 0, 0, '0, 8'h00, 0, 1, "R8");

    // R10 lock
    sr_write(8'h10, "R6");
    sr_write(8'h40, "R6");
    step(1, 0, 0, 0, '0, 8'h00, 0, 0, "R3");
    step(0, 0, 1, 0, 17'h00000, 8'h00, 0, 0, "R7");
    sr_write(8'h00, "R10");
    chk("R10", status[4], 1'b1);

    // R12 retention through reset
    sr_write(8'h88, "R6");
    step(1, 0, 0, 0, '0, 8'h00, 0, 0, "R3");
    do_reset();
    chk("R12", status, 8'b1001_1000);

    // R4 R5 R6 sweep
    for (int pe = 0; pe < 2; pe++) begin
      for (int bp = 0; bp < 4; bp++) begin
        wp_n = 1;
        sr_write({pe[0], 3'b000, bp[1:0], 2'b00}, "R6");
        for (int wl = 0; wl < 2; wl++) begin
          for (int wp = 0; wp < 2; wp++) begin
            for (int k = 0; k < 7; k++) begin
              wp_n = wp[0];
              step(wl[0], !wl[0], 0, 0, '0, 8'h00, 0, 0, "R3");
              if (k == 6)
                step(0, 0, 1, 1, '0, {pe[0], 3'b000, bp[1:0], 2'b00}, 0, 0, "R5 R6");
              else
                step(0, 0, 1, 0, pts[k], 8'h00, 0, 0, "R4 R5");
              if (m_busy) step(0, 0, 0, 0, '0, 8'h00, 1, 0, "R2");
            end
          end
        end
      end
    end
    wp_n = 1;

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule